// File: doc/BRIEF.md
# Asynchronous Memory Read Sequencer with Wait Hold

This block runs a read access to an external asynchronous parallel memory. A request starts a timeline that advances in steps of a divided interface clock. A cycle counter counts those steps, and the chip select, address-valid and output-enable strobes are each active over a window between a programmed start count and a programmed stop count. A direction output shows who drives the data bus: it turns to the memory side once output enable is due.

When the counter reaches the programmed access time, the block looks at the active-low wait pin and then captures data. The wait level reaches the decision through a two-step pipeline clocked by the divided enable. While the pipeline reports wait, the counter stays at the access time. Once wait is seen released, an optional extra delay of 0 to 3 divided steps runs, then a capture pulse marks the data as valid.

A burst repeats this wait-and-capture point for each further word, with the counter held at the access time throughout. After the last capture the counter runs on to the programmed cycle end. It raises a one-clock done pulse there and returns to idle.

States: `ST_IDLE` (waiting for a request), `ST_LEAD` (counting up to the access time), `ST_SAMPLE` (counter locked at the access time, evaluating wait for the current word), `ST_XDLY` (extra delay after wait release), `ST_TAIL` (counting from the last capture to the cycle end). Transitions: request taken (`ST_IDLE`→`ST_LEAD`, or →`ST_SAMPLE` when the access time is zero), access time reached (`ST_LEAD`→`ST_SAMPLE`), wait held (`ST_SAMPLE`→`ST_SAMPLE`), release with delay (`ST_SAMPLE`→`ST_XDLY`), word captured with more to come (→`ST_SAMPLE`), last word captured (→`ST_TAIL`), cycle end (`ST_TAIL`→`ST_IDLE`).

Top module: `arw_seq`

## Requirements
- R1: A step enable fires once every `div_sel`+1 functional clocks. The phase of the enable restarts on the clock edge that takes a request, so the first step comes `div_sel`+1 clocks after that edge. The cycle counter, the wait pipeline and the delay counter change only on steps.
- R2: While busy, `cs_n`, `adv_n` and `oe_n` are low exactly when the counter value c satisfies on <= c < off for their own start/stop pair. In idle all three are high.
- R3: `dir` is 1 (memory drives the bus) while busy with counter >= `t_oe_on`, and 0 otherwise.
- R4: `wait_n` is active low. A level sampled at step k is used at the decision of step k+2. At a decision step with the counter at `t_acc`, an active level keeps the counter at `t_acc` and delays the capture by one step.
- R5: When wait is seen inactive at decision step j, capture happens at step j+`wmon` (`wmon` is 0..3). During these extra steps wait is not re-evaluated and the counter stays at `t_acc`.
- R6: A request with `burst_len`=L yields L+1 captures. After a capture that is not the last, the next word's wait decision is made on the following step, and the counter stays at `t_acc` (a counter at access time 0 counts from the first step).
- R7: The last capture moves the counter to `t_acc`+1. The counter then rises one per step until a step finds it equal to `t_cyc`; there `done` pulses and the block goes idle. This requires `t_cyc` > `t_acc`.
- R8: `cap` and `done` are high for exactly the one functional clock that follows their step edge.
- R9: `req` is taken only in idle. A request while busy changes no output timing.
- R10: After reset the block is idle, all strobes are high, and `dir`, `cap` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 2 | Step period minus one, in functional clocks |
| t_cs_on | input | 5 | Chip-select start count |
| t_cs_off | input | 5 | Chip-select stop count |
| t_adv_on | input | 5 | Address-valid start count |
| t_adv_off | input | 5 | Address-valid stop count |
| t_oe_on | input | 5 | Output-enable start count |
| t_oe_off | input | 5 | Output-enable stop count |
| t_acc | input | 5 | Access time (wait decision count) |
| t_cyc | input | 5 | Cycle end count |
| wmon | input | 2 | Extra steps between wait release and capture |
| req | input | 1 | Start request |
| burst_len | input | 3 | Words in the access minus one |
| wait_n | input | 1 | Active-low wait from the memory |
| cs_n | output | 1 | Chip select, active low |
| adv_n | output | 1 | Address valid, active low |
| oe_n | output | 1 | Output enable, active low |
| dir | output | 1 | Bus direction, 1 = memory drives |
| cap | output | 1 | Read data capture pulse |
| done | output | 1 | Access complete pulse |

## Verification
All results are timed from the edge that takes the request. Every registered change lands on a step edge, at a multiple of `div_sel`+1 clocks after it. The bench builds a per-step table of counter value, busy, capture and done from the requirements. It derives capture steps by walking decision steps: each decision step looks at the wait level driven two steps earlier, and the extra delay is added after release. The strobes and `dir` are then checked in every clock from the count of the latest step. The `cap` and `done` pulses are expected only in the first clock after their step edge. Wait is changed only before step edges, so the two-step latency is counted exactly.

// File: rtl/arw_pkg.sv
package arw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LEAD   = 3'd1,
        ST_SAMPLE = 3'd2,
        ST_XDLY   = 3'd3,
        ST_TAIL   = 3'd4
    } arw_state_e;

    localparam int NWIN      = 3;   // cs, adv, oe
    localparam int WIN_CS    = 0;
    localparam int WIN_ADV   = 1;
    localparam int WIN_OE    = 2;
    localparam int WAIT_PIPE = 2;   // detection latency in steps
endpackage

// File: rtl/arw_tick.sv
module arw_tick #(
    parameter int DW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [DW-1:0] sel,
    output logic          tick
);
    logic [DW-1:0] dcnt;

    assign tick = (dcnt == sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dcnt <= '0;
        end else if (restart || tick) begin
            dcnt <= '0;
        end else begin
            dcnt <= dcnt + 1'b1;
        end
    end
endmodule

// File: rtl/arw_wsync.sv
module arw_wsync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic wait_n,
    output logic wait_act
);
    logic [DEPTH-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr[0] <= 1'b0;
        end else if (tick) begin
            sr[0] <= ~wait_n;
        end
    end

    generate
        for (genvar g = 1; g < DEPTH; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sr[g] <= 1'b0;
                end else if (tick) begin
                    sr[g] <= sr[g-1];
                end
            end
        end
    endgenerate

    assign wait_act = sr[DEPTH-1];
endmodule

// File: rtl/arw_win.sv
module arw_win #(
    parameter int TW = 5
) (
    input  logic          en,
    input  logic [TW-1:0] cnt,
    input  logic [TW-1:0] t_on,
    input  logic [TW-1:0] t_off,
    output logic          act
);
    assign act = en && (cnt >= t_on) && (cnt < t_off);
endmodule

// File: rtl/arw_seq.sv
module arw_seq
    import arw_pkg::*;
#(
    parameter int TW = 5,
    parameter int DW = 2,
    parameter int MW = 2,
    parameter int BW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] div_sel,
    input  logic [TW-1:0] t_cs_on,
    input  logic [TW-1:0] t_cs_off,
    input  logic [TW-1:0] t_adv_on,
    input  logic [TW-1:0] t_adv_off,
    input  logic [TW-1:0] t_oe_on,
    input  logic [TW-1:0] t_oe_off,
    input  logic [TW-1:0] t_acc,
    input  logic [TW-1:0] t_cyc,
    input  logic [MW-1:0] wmon,
    input  logic          req,
    input  logic [BW-1:0] burst_len,
    input  logic          wait_n,
    output logic          cs_n,
    output logic          adv_n,
    output logic          oe_n,
    output logic          dir,
    output logic          cap,
    output logic          done
);
    arw_state_e    st, st_nx;
    logic [TW-1:0] cnt, cnt_nx;
    logic [BW-1:0] beats, beats_nx;
    logic [MW-1:0] dly, dly_nx;
    logic          cap_nx, done_nx;
    logic          restart, tick, wait_act, take_word, busy;
    logic [TW-1:0] cnt_inc;
    logic [NWIN-1:0] win_act;
    logic [TW-1:0]   win_on  [NWIN];
    logic [TW-1:0]   win_off [NWIN];

    assign cnt_inc = cnt + 1'b1;

    arw_tick #(.DW(DW)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .sel     (div_sel),
        .tick    (tick)
    );

    arw_wsync #(.DEPTH(WAIT_PIPE)) u_wsync (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .wait_n   (wait_n),
        .wait_act (wait_act)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            beats <= '0;
            dly   <= '0;
            cap   <= 1'b0;
            done  <= 1'b0;
        end else begin
            st    <= st_nx;
            cnt   <= cnt_nx;
            beats <= beats_nx;
            dly   <= dly_nx;
            cap   <= cap_nx;
            done  <= done_nx;
        end
    end

    // next-state logic
    always_comb begin
        st_nx     = st;
        cnt_nx    = cnt;
        beats_nx  = beats;
        dly_nx    = dly;
        cap_nx    = 1'b0;
        done_nx   = 1'b0;
        restart   = 1'b0;
        take_word = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (req) begin
                    restart  = 1'b1;
                    cnt_nx   = '0;
                    beats_nx = burst_len;
                    st_nx    = (t_acc == '0) ? ST_SAMPLE : ST_LEAD;
                end
            end
            ST_LEAD: begin
                if (tick) begin
                    cnt_nx = cnt_inc;
                    if (cnt_inc == t_acc) begin
                        st_nx = ST_SAMPLE;
                    end
                end
            end
            ST_SAMPLE: begin
                if (tick && !wait_act) begin
                    if (wmon == '0) begin
                        take_word = 1'b1;
                    end else begin
                        dly_nx = wmon;
                        st_nx  = ST_XDLY;
                    end
                end
            end
            ST_XDLY: begin
                if (tick) begin
                    if (dly == MW'(1)) begin
                        take_word = 1'b1;
                    end else begin
                        dly_nx = dly - 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    if (cnt == t_cyc) begin
                        done_nx = 1'b1;
                        cnt_nx  = '0;
                        st_nx   = ST_IDLE;
                    end else begin
                        cnt_nx = cnt_inc;
                    end
                end
            end
            default: st_nx = ST_IDLE;
        endcase

        if (take_word) begin
            cap_nx = 1'b1;
            if (beats == '0) begin
                cnt_nx = cnt_inc;
                st_nx  = ST_TAIL;
            end else begin
                beats_nx = beats - 1'b1;
                st_nx    = ST_SAMPLE;
            end
        end
    end

    // strobe windows
    assign win_on[WIN_CS]   = t_cs_on;
    assign win_off[WIN_CS]  = t_cs_off;
    assign win_on[WIN_ADV]  = t_adv_on;
    assign win_off[WIN_ADV] = t_adv_off;
    assign win_on[WIN_OE]   = t_oe_on;
    assign win_off[WIN_OE]  = t_oe_off;

    generate
        for (genvar w = 0; w < NWIN; w++) begin : g_win
            arw_win #(.TW(TW)) u_win (
                .en    (busy),
                .cnt   (cnt),
                .t_on  (win_on[w]),
                .t_off (win_off[w]),
                .act   (win_act[w])
            );
        end
    endgenerate

    // outputs
    always_comb begin
        busy  = (st != ST_IDLE);
        cs_n  = ~win_act[WIN_CS];
        adv_n = ~win_act[WIN_ADV];
        oe_n  = ~win_act[WIN_OE];
        dir   = busy && (cnt >= t_oe_on);
    end
endmodule

// File: rtl/arw_seq_chk.sv
module arw_seq_chk
    import arw_pkg::*;
#(
    parameter int TW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          wait_act,
    input arw_state_e    st,
    input logic [TW-1:0] cnt,
    input logic [TW-1:0] t_acc,
    input logic [TW-1:0] t_cyc,
    input logic          cs_n,
    input logic          adv_n,
    input logic          oe_n,
    input logic          dir,
    input logic          cap,
    input logic          done
);
    // R10 / R2: idle keeps every strobe released
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (cs_n && adv_n && oe_n && !dir));

    // R1: counter moves only on a step while busy
    p_step_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && $past(st) != ST_IDLE && !$past(tick)) |-> $stable(cnt));

    // R4: wait seen active at the decision keeps the counter locked
    p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tick) && $past(wait_act) && $past(st) == ST_SAMPLE)
            |-> (st == ST_SAMPLE && $stable(cnt) && !cap));

    // R8: done is a single-clock pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done lands on the return to idle
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (st == ST_IDLE));

    // R7: counter never passes the cycle end
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && t_cyc > t_acc) |-> (cnt <= t_cyc));
endmodule

bind arw_seq arw_seq_chk #(.TW(TW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .wait_act (wait_act),
    .st       (st),
    .cnt      (cnt),
    .t_acc    (t_acc),
    .t_cyc    (t_cyc),
    .cs_n     (cs_n),
    .adv_n    (adv_n),
    .oe_n     (oe_n),
    .dir      (dir),
    .cap      (cap),
    .done     (done)
);

// File: tb/arw_seq_tb_top.sv
module arw_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] div_sel = '0;
    logic [4:0] t_cs_on = '0, t_cs_off = '0, t_adv_on = '0, t_adv_off = '0;
    logic [4:0] t_oe_on = '0, t_oe_off = '0, t_acc = '0, t_cyc = '0;
    logic [1:0] wmon = '0;
    logic       req = 1'b0;
    logic [2:0] burst_len = '0;
    logic       wait_n = 1'b1;
    logic       cs_n, adv_n, oe_n, dir, cap, done;

    int checks = 0;
    int errors = 0;
    int wcase  = 0;
    int acc_i, cyc_i;

    int ecnt [128];
    bit ecap [128];
    bit edone[128];
    bit ebusy[128];
    int jd;

    always #2.5 clk = ~clk;

    arw_seq dut_i (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel),
        .t_cs_on(t_cs_on), .t_cs_off(t_cs_off),
        .t_adv_on(t_adv_on), .t_adv_off(t_adv_off),
        .t_oe_on(t_oe_on), .t_oe_off(t_oe_off),
        .t_acc(t_acc), .t_cyc(t_cyc), .wmon(wmon), .req(req),
        .burst_len(burst_len), .wait_n(wait_n),
        .cs_n(cs_n), .adv_n(adv_n), .oe_n(oe_n), .dir(dir),
        .cap(cap), .done(done)
    );

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run did not end (actual hung, expected finish)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // wait active at sample step s (R4 stimulus)
    function automatic bit win_active(input int s);
        if (wcase == 1) return (s >= acc_i - 1) && (s < acc_i + 3);
        if (wcase == 2) return (s == acc_i + 1);
        return 1'b0;
    endfunction

    // per-step expectation from R4..R7
    task automatic build_model();
        int j;
        int cv;
        for (int t = 0; t < 128; t++) begin
            ecnt[t] = 0; ecap[t] = 0; edone[t] = 0; ebusy[t] = 0;
        end
        ebusy[0] = 1;
        for (int t = 1; t <= acc_i; t++) begin
            ecnt[t] = t; ebusy[t] = 1;
        end
        j = acc_i + 1;
        for (int b = 0; b <= int'(burst_len); b++) begin
            while (win_active(j - 2)) begin
                ecnt[j] = acc_i; ebusy[j] = 1; j++;
            end
            for (int k = 0; k < int'(wmon); k++) begin
                ecnt[j] = acc_i; ebusy[j] = 1; j++;
            end
            ecap[j]  = 1;
            ebusy[j] = 1;
            ecnt[j]  = (b == int'(burst_len)) ? acc_i + 1 : acc_i;
            j++;
        end
        cv = acc_i + 1;
        forever begin
            if (cv == cyc_i) begin
                edone[j] = 1; ecnt[j] = 0; ebusy[j] = 0; jd = j;
                break;
            end
            cv++;
            ecnt[j] = cv; ebusy[j] = 1; j++;
        end
    endtask

    task automatic run_one();
        int n;
        int t;
        int c;
        bit ph;
        bit eb;
        int ec;
        n = int'(div_sel) + 1;
        build_model();
        @(negedge clk);
        req = 1'b1;
        wait_n = 1'b1;
        @(posedge clk);
        c = 0;
        forever begin
            @(negedge clk);
            if (c >= 1) begin
                t  = c / n;
                ph = (c % n) == 0;
                eb = (t <= jd) ? ebusy[t] : 1'b0;
                ec = (t <= jd) ? ecnt[t] : 0;
                chk("R2 cs_n", cs_n, !(eb && ec >= int'(t_cs_on) && ec < int'(t_cs_off)));
                chk("R2 adv_n", adv_n, !(eb && ec >= int'(t_adv_on) && ec < int'(t_adv_off)));
                chk("R2 oe_n", oe_n, !(eb && ec >= int'(t_oe_on) && ec < int'(t_oe_off)));
                chk("R3 dir", dir, eb && ec >= int'(t_oe_on));
                chk("R5 R6 R8 cap", cap, (t <= jd) && ecap[t] && ph);
                chk("R7 R8 done", done, (t <= jd) && edone[t] && ph);
            end
            // R9: a second request while busy must be ignored
            req = (c == 2 * n + 1);
            // R4: drive the level sampled at the coming step edge
            if (((c + 1) % n) == 0) wait_n = !win_active((c + 1) / n);
            if (c > (jd + 1) * n) break;
            @(posedge clk);
            c++;
        end
        req = 1'b0;
        wait_n = 1'b1;
        repeat (10) @(posedge clk);
    endtask

    initial begin
        // R10: reset state
        #12;
        @(negedge clk);
        chk("R10 cs_n", cs_n, 1);
        chk("R10 adv_n", adv_n, 1);
        chk("R10 oe_n", oe_n, 1);
        chk("R10 dir", dir, 0);
        chk("R10 cap", cap, 0);
        chk("R10 done", done, 0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);

        // R1: divider sweep; R4..R7 across waits, delays and bursts
        for (int ts = 0; ts < 2; ts++) begin
            if (ts == 0) begin
                t_cs_on = 0; t_cs_off = 9; t_adv_on = 1; t_adv_off = 3;
                t_oe_on = 3; t_oe_off = 8; t_acc = 5; t_cyc = 10;
            end else begin
                t_cs_on = 0; t_cs_off = 4; t_adv_on = 0; t_adv_off = 1;
                t_oe_on = 1; t_oe_off = 4; t_acc = 2; t_cyc = 4;
            end
            acc_i = int'(t_acc);
            cyc_i = int'(t_cyc);
            for (int d = 0; d < 4; d++) begin
                for (int m = 0; m < 4; m++) begin
                    for (int bl = 0; bl < 3; bl++) begin
                        for (int wc = 0; wc < 3; wc++) begin
                            div_sel   = d[1:0];
                            wmon      = m[1:0];
                            burst_len = bl[2:0];
                            wcase     = wc;
                            run_one();
                        end
                    end
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule